// File: doc/BRIEF.md
# PS/2 Port Register Block

A bus-attached register block for a single PS/2 keyboard or mouse channel. A host reaches it through a 32-bit register bus with a byte address and separate read and write strobes. Through that bus the host reads and writes a control word and a clock-divisor word. It reads a status word, a data word and an interrupt-status word, and it can read an identification area near the top of the 4 KiB window. The line-level serial engine sits outside the block. It presents a "byte available" level and the received byte. It takes a one-cycle pop strobe each time a pending byte is consumed, and a transmit byte qualified by a one-cycle valid strobe.

Read data is combinational in the cycle of the read strobe. The data-word latch and the pop act on the clock edge that closes the access. The interrupt output is a level. The receive interrupt depends on the pending input gated by one control bit. A second control bit forces the interrupt high, because the transmit side always reports empty.

Top module: `ps2_port_regs`

## Requirements
- R1: The word index is the byte address shifted right by two. Index 0 is the control word and reads back exactly the last value written to it. Index 3 is the divisor word, which also reads back exactly as written and has no effect on any other output.
- R2: Byte addresses 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC read the bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 respectively, in bits 7:0, with the upper bits 0.
- R3: The status word (index 1) always has bit 6 set. Bit 4 equals the byte-available input. Bit 2 is the XOR of all eight bits of the latched data byte. All other bits are 0.
- R4: A read of the data word (index 2) while a byte is available returns the device byte in bits 7:0 in that cycle. It raises dev_pop for exactly that cycle, and the byte becomes the latched byte from the next cycle on.
- R5: A read of the data word with no byte available returns the latched byte, leaves dev_pop low and leaves the latch unchanged.
- R6: irq equals (byte available AND control bit 4) OR control bit 3. It follows a change in the control word from the cycle after the write, and follows the available input in the same cycle.
- R7: The interrupt-status word (index 4) reads with bit 1 set, bit 0 equal to the byte-available input, and all other bits 0.
- R8: A write to the data word drives dev_tx_valid high for exactly that cycle, with dev_tx_byte equal to bits 7:0 of the write data.
- R9: A read of any other address returns 0, and bus_rdata is 0 when no read strobe is active. Writes to other addresses and to the read-only words change no register and raise no strobe.
- R10: After reset the control word, divisor word and latched byte are 0. The status word then reads 0x40 with nothing available, and irq is low.
- R11: A read and a write of the data word in the same cycle perform both actions: the pop and latch of R4 and the transmit strobe of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt |
| dev_avail | input | 1 | Device has a received byte waiting |
| dev_rx_byte | input | 8 | Received byte from the device |
| dev_pop | output | 1 | One-cycle consume strobe to the device |
| dev_tx_byte | output | 8 | Byte to transmit |
| dev_tx_valid | output | 1 | One-cycle qualifier for dev_tx_byte |

## Verification
Two pairs of actions can share a cycle. The first pair is a pop and a transmit: the bench raises read and write strobes together on the data word, then expects the pop, the transmit strobe and the device byte on the read bus in that cycle. A later plain read with nothing available must return that byte. The second pair is a change of the control word and a change of the available input. The bench sweeps every combination of the two interrupt control bits against the available level and compares irq with the OR/AND formula. The parity bit and the data read path are swept over all 256 byte values.

// File: rtl/ps2_port_regs.sv
module ps2_port_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RXIE_BIT = 4,
  parameter int TXIE_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              dev_avail,
  input  logic [7:0]        dev_rx_byte,
  output logic              dev_pop,
  output logic [7:0]        dev_tx_byte,
  output logic              dev_tx_valid
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_DIV  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_INTS = IDX_W'(4);

  logic [DATA_W-1:0] ctrl_q, div_q;
  logic [7:0]        last_q;
  logic [IDX_W-1:0]  widx;
  logic              id_hit;
  logic              sel_ctrl, sel_data, sel_div;
  logic [7:0]        data_now;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  assign widx     = bus_addr[ADDR_W-1:2];
  assign id_hit   = &bus_addr[ADDR_W-1:5];
  assign sel_ctrl = !id_hit && widx == IDX_CTRL;
  assign sel_data = !id_hit && widx == IDX_DATA;
  assign sel_div  = !id_hit && widx == IDX_DIV;

  assign dev_pop      = bus_rd && sel_data && dev_avail;
  assign data_now     = dev_pop ? dev_rx_byte : last_q;
  assign dev_tx_valid = bus_wr && sel_data;
  assign dev_tx_byte  = bus_wdata[7:0];
  assign irq          = (dev_avail && ctrl_q[RXIE_BIT]) || ctrl_q[TXIE_BIT];

  always_comb begin
    rd_mux = '0;
    if (id_hit) begin
      rd_mux[7:0] = id_byte(bus_addr[4:2]);
    end else begin
      case (widx)
        IDX_CTRL: rd_mux = ctrl_q;
        IDX_STAT: begin
          rd_mux[6] = 1'b1;
          rd_mux[4] = dev_avail;
          rd_mux[2] = ^last_q;
        end
        IDX_DATA: rd_mux[7:0] = data_now;
        IDX_DIV:  rd_mux = div_q;
        IDX_INTS: rd_mux[1:0] = {1'b1, dev_avail};
        default:  rd_mux = '0;
      endcase
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      last_q <= '0;
    end else begin
      if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata;
      if (bus_wr && sel_div)  div_q  <= bus_wdata;
      if (dev_pop)            last_q <= dev_rx_byte;
    end
  end

  // R4
  latch_takes_popped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_pop |=> last_q == $past(dev_rx_byte));
  // R5
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_pop |=> $stable(last_q));
  // R1
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl) |=> ctrl_q == $past(bus_wdata));
  // R9
  div_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_div) |=> $stable(div_q));
  // R9
  ctrl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_ctrl) |=> $stable(ctrl_q));
  // R6
  irq_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl && bus_wdata[TXIE_BIT]) |=> irq);
endmodule

// File: tb/tb_ps2_port_regs.sv
module tb_ps2_port_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        dev_avail = 0;
  logic [7:0]  dev_rx_byte = '0;
  logic        dev_pop;
  logic [7:0]  dev_tx_byte;
  logic        dev_tx_valid;

  int checks = 0, errors = 0;

  ps2_port_regs dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic p);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1;
    d = bus_rdata; p = dev_pop;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v, output logic tv, output logic [7:0] tb);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = v;
    #1;
    tv = dev_tx_valid; tb = dev_tx_byte;
    @(negedge clk);
    bus_wr = 0;
    #1;
    if (dev_tx_valid) chk(0, "R8 strobe length", 1, 0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic p, tv;
    logic [7:0] tb;
    logic [7:0] ids [8];
    ids = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    #1; chk(irq == 0, "R10 irq", irq, 0);
    rd(12'h004, d, p); chk(d == 32'h40, "R10 status", d, 32'h40);
    rd(12'h000, d, p); chk(d == 0, "R10 ctrl", d, 0);
    rd(12'h00C, d, p); chk(d == 0, "R10 div", d, 0);
    rd(12'h008, d, p); chk(d == 0 && !p, "R10 data", d, 0);
    #1; chk(bus_rdata == 0, "R9 idle rdata", bus_rdata, 0);

    // R2 identification bytes
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(k*4), d, p);
      chk(d == {24'h0, ids[k]}, "R2 id", d, {24'h0, ids[k]});
    end

    // R1 control and divisor readback
    for (int k = 0; k < 16; k++) begin
      logic [31:0] v = 32'h9E37_79B9 * (k + 1);
      v[3] = 0;
      wr(12'h000, v, tv, tb); rd(12'h000, d, p);
      chk(d == v, "R1 ctrl", d, v);
      wr(12'h00C, ~v, tv, tb); rd(12'h00C, d, p);
      chk(d == ~v, "R1 div", d, ~v);
      #1; chk(!tv, "R9 no tx on div", tv, 0);
    end
    wr(12'h000, 0, tv, tb);

    // R3 R4 R5 sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); dev_avail = 1; dev_rx_byte = 8'(v);
      rd(12'h004, d, p);
      chk(d[4] == 1, "R3 rx full", d, 32'h10);
      rd(12'h008, d, p);
      chk(d == v && p, "R4 pop read", {d[30:0], p}, {23'h0, 8'(v), 1'b1});
      @(negedge clk); dev_avail = 0; dev_rx_byte = 8'(~v);
      rd(12'h004, d, p);
      chk(d == (32'h40 | (32'(^8'(v)) << 2)), "R3 status parity", d, 32'h40 | (32'(^8'(v)) << 2));
      rd(12'h008, d, p);
      chk(d == v && !p, "R5 no pop", {d[30:0], p}, {23'h0, 8'(v), 1'b0});
    end

    // R6 irq and R7 interrupt status over all combinations
    for (int c = 0; c < 8; c++) begin
      logic a = c[0], rxie = c[1], txie = c[2];
      wr(12'h000, {27'h0, rxie, txie, 3'b0}, tv, tb);
      @(negedge clk); dev_avail = a; #1;
      chk(irq == ((a && rxie) || txie), "R6 irq", irq, (a && rxie) || txie);
      rd(12'h010, d, p);
      chk(d == {30'h0, 1'b1, a}, "R7 int status", d, {30'h0, 1'b1, a});
    end
    @(negedge clk); dev_avail = 0;
    wr(12'h000, 32'h0000_0010, tv, tb);
    wr(12'h00C, 32'hFFFF_FFFF, tv, tb); #1;
    chk(irq == 0, "R1 div no irq effect", irq, 0);

    // R8 transmit
    for (int v = 0; v < 256; v += 17) begin
      wr(12'h008, {24'hABCDEF, 8'(v)}, tv, tb);
      chk(tv && tb == v, "R8 tx", {23'h0, tv, tb}, {23'h0, 1'b1, 8'(v)});
    end

    // R9 unmapped reads and ignored writes
    for (int i = 5; i < 12'h3F8; i++) begin
      rd(12'(i*4), d, p);
      if (d != 0) chk(0, "R9 unmapped read", d, 0);
    end
    chk(1, "R9 unmapped sweep", 0, 0);
    wr(12'h004, 32'hFFFF_FFFF, tv, tb); chk(!tv, "R9 status write", tv, 0);
    wr(12'h010, 32'hFFFF_FFFF, tv, tb); chk(!tv, "R9 ints write", tv, 0);
    wr(12'h100, 32'hFFFF_FFFF, tv, tb); chk(!tv, "R9 unmapped write", tv, 0);
    wr(12'hFE8, 32'hFFFF_FFFF, tv, tb); chk(!tv, "R9 id write", tv, 0);
    rd(12'h000, d, p); chk(d == 32'h10, "R9 ctrl kept", d, 32'h10);
    rd(12'h00C, d, p); chk(d == 32'hFFFF_FFFF, "R9 div kept", d, 32'hFFFF_FFFF);
    rd(12'hFE8, d, p); chk(d == 32'h04, "R9 id kept", d, 32'h04);
    rd(12'h008, d, p); chk(d == 8'hFF && !p, "R9 latch kept", d, 32'hFF);

    // R11 pop and transmit in the same cycle
    @(negedge clk);
    dev_avail = 1; dev_rx_byte = 8'h96;
    bus_addr = 12'h008; bus_rd = 1; bus_wr = 1; bus_wdata = 32'h0000_003C;
    #1;
    chk(dev_pop && dev_tx_valid, "R11 both strobes", {dev_pop, dev_tx_valid}, 2'b11);
    chk(bus_rdata == 32'h96 && dev_tx_byte == 8'h3C, "R11 data", {bus_rdata[7:0], dev_tx_byte}, 16'h963C);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; dev_avail = 0;
    rd(12'h008, d, p); chk(d == 32'h96 && !p, "R11 latched", d, 32'h96);
    rd(12'h004, d, p); chk(d == 32'h40, "R11 parity even", d, 32'h40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule